// File: doc/BRIEF.md
# Load-Aware Interrupt Steering Distributor

This block routes device interrupt requests to the processors of a shared-memory multiprocessor, up to eight of them. Each processor owns a steering register and writes its current state into it. The state is either an interrupt mask threshold or one of two thread-level codes: one says the processor is running its idle task, the other says it is doing normal work with nothing masked.

Each source is configured in one of two ways. It can be pinned to one processor. It can also be left free, and then the hardware picks a target anew at every event from the steering registers. Idle processors are chosen first. If none is idle, any processor that does not mask the source is chosen. A rotating pointer breaks ties.

A delivered interrupt raises the target's interrupt line and shows the source index next to it. The line stays up until that processor acknowledges. A request that cannot be delivered stays pending and is evaluated again on every cycle.

Top module: `irq_steer`

## Requirements
- R1: After reset every steering register holds the all-ones code, which masks every level, and all interrupt lines are low. A request made before any register write is not delivered.
- R2: A steering code with its top bit clear is a mask threshold held in the low LVL_W bits. A source of level L is deliverable to that processor only when L is greater than the threshold.
- R3: Code 0x8 means idle and code 0x9 means busy. Both accept every level. Every other code with the top bit set (0xA to 0xF) masks all levels.
- R4: A source configured as pinned is delivered only to its configured processor and ignores the idle and busy codes. It waits only until that processor's code admits its level.
- R5: A free source goes to an idle processor whenever an available idle processor admits it, even if a non-idle eligible processor comes earlier in the scan.
- R6: When no eligible processor is idle, a free source goes to any processor that admits its level and holds no outstanding interrupt.
- R7: Among equal candidates the scan starts at the pointer and wraps. After each free-source delivery the pointer moves to the processor after the chosen one. Pinned deliveries leave the pointer unchanged.
- R8: A request with no eligible target stays pending. It is delivered on the cycle after a steering register write makes a target eligible.
- R9: A delivered interrupt holds irq_o[c] high with a stable irq_src_o slice until irq_ack_i[c] is sampled. The line is low the next cycle. A processor that holds an outstanding interrupt is not eligible for another.
- R10: A request from a source that is already pending or awaiting acknowledge is merged. It causes no second delivery.
- R11: At most one interrupt is dispatched per cycle, and the lowest-index pending source that has a candidate goes first.
- R12: A request sampled at clock edge k, with an eligible target, raises the interrupt line after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| steer_we_i | input | N_CPU | Per-processor steering register write enable |
| steer_wdata_i | input | N_CPU*(LVL_W+1) | Per-processor steering code |
| src_req_i | input | N_SRC | Interrupt event pulse per source |
| src_any_i | input | N_SRC | 1: free routing, 0: pinned |
| src_cpu_i | input | N_SRC*CPU_W | Pinned target per source |
| src_lvl_i | input | N_SRC*LVL_W | Interrupt level per source |
| irq_ack_i | input | N_CPU | Per-processor acknowledge |
| irq_o | output | N_CPU | Per-processor interrupt line |
| irq_src_o | output | N_CPU*SRC_W | Source index shown on each raised line |

## Verification
A corrupted round-robin pointer shows at the next free-source delivery, because the interrupt appears on a processor other than the one predicted from the scan order. A wrong decode of a steering code shows one cycle after the write, as a delivery to a processor that should mask it or as a pending request that never rises. A lost tracker state shows as a line that drops without an acknowledge, or as a second delivery of a merged request. The scoreboard catches either one within one cycle of the rise.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PEND = 2'd1,
    SRC_WAIT = 2'd2
  } src_st_e;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs #(
  parameter int N_CPU = 8,
  parameter int LVL_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CPU-1:0]             we_i,
  input  logic [N_CPU*(LVL_W+1)-1:0]   wdata_i,
  output logic [N_CPU*(LVL_W+1)-1:0]   steer_o,
  output logic [N_CPU-1:0]             idle_o,
  output logic [N_CPU-1:0]             open_o,
  output logic [N_CPU-1:0]             thr_on_o,
  output logic [N_CPU*LVL_W-1:0]       thr_o
);
  localparam int REG_W = LVL_W + 1;
  localparam logic [REG_W-1:0] CODE_IDLE = {1'b1, {LVL_W{1'b0}}};
  localparam logic [REG_W-1:0] CODE_BUSY = {1'b1, {(LVL_W-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '1;
      else if (we_i[c]) q <= wdata_i[c*REG_W +: REG_W];
    end
    assign steer_o[c*REG_W +: REG_W] = q;
    assign idle_o[c]   = (q == CODE_IDLE);
    assign open_o[c]   = (q == CODE_IDLE) || (q == CODE_BUSY);
    assign thr_on_o[c] = ~q[LVL_W];
    assign thr_o[c*LVL_W +: LVL_W] = q[LVL_W-1:0];
  end
endmodule

// File: rtl/irq_steer_rr.sv
module irq_steer_rr #(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic          vld_o,
  output logic [PW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (int'(ptr_i) + i) % N;
      if (!vld_o && req_i[k]) begin
        vld_o = 1'b1;
        idx_o = PW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_steer_track.sv
module irq_steer_track
  import irq_steer_pkg::*;
#(
  parameter int N_CPU = 8,
  parameter int CPU_W = $clog2(N_CPU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             grant_i,
  input  logic [CPU_W-1:0] gcpu_i,
  input  logic [N_CPU-1:0] ack_i,
  output logic             pend_o,
  output logic             wait_o,
  output logic [CPU_W-1:0] cpu_o
);
  src_st_e          st_q;
  logic [CPU_W-1:0] cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SRC_IDLE;
      cpu_q <= '0;
    end else begin
      unique case (st_q)
        SRC_IDLE: if (req_i) st_q <= SRC_PEND;
        SRC_PEND: if (grant_i) begin
          st_q  <= SRC_WAIT;
          cpu_q <= gcpu_i;
        end
        SRC_WAIT: if (ack_i[cpu_q]) st_q <= SRC_IDLE;
        default:  st_q <= SRC_IDLE;
      endcase
    end
  end

  assign pend_o = (st_q == SRC_PEND);
  assign wait_o = (st_q == SRC_WAIT);
  assign cpu_o  = cpu_q;
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int N_CPU = 8,
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int CPU_W = $clog2(N_CPU),
  parameter int SRC_W = $clog2(N_SRC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CPU-1:0]           steer_we_i,
  input  logic [N_CPU*(LVL_W+1)-1:0] steer_wdata_i,
  input  logic [N_SRC-1:0]           src_req_i,
  input  logic [N_SRC-1:0]           src_any_i,
  input  logic [N_SRC*CPU_W-1:0]     src_cpu_i,
  input  logic [N_SRC*LVL_W-1:0]     src_lvl_i,
  input  logic [N_CPU-1:0]           irq_ack_i,
  output logic [N_CPU-1:0]           irq_o,
  output logic [N_CPU*SRC_W-1:0]     irq_src_o
);
  localparam int REG_W = LVL_W + 1;

  logic [N_CPU*REG_W-1:0] steer_q;
  logic [N_CPU-1:0]       idle_v, open_v, thr_on;
  logic [N_CPU*LVL_W-1:0] thr_v;

  irq_steer_regs #(.N_CPU(N_CPU), .LVL_W(LVL_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (steer_we_i),
    .wdata_i  (steer_wdata_i),
    .steer_o  (steer_q),
    .idle_o   (idle_v),
    .open_o   (open_v),
    .thr_on_o (thr_on),
    .thr_o    (thr_v)
  );

  logic [N_SRC-1:0] pend, waiting, grant, has_cand;
  logic [CPU_W-1:0] trk_cpu [N_SRC];
  logic [N_CPU-1:0] cand    [N_SRC];
  logic [CPU_W-1:0] rr_q, gnt_cpu;
  logic             gnt_vld;
  logic [SRC_W-1:0] sel_src;
  logic             sel_vld;

  // a processor holding an unacknowledged interrupt is not a candidate
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [LVL_W-1:0] lvl;
    logic [N_CPU-1:0] avail, tier;
    assign lvl = src_lvl_i[s*LVL_W +: LVL_W];
    for (genvar c = 0; c < N_CPU; c++) begin : g_del
      assign avail[c] = ~irq_o[c] &
                        (open_v[c] | (thr_on[c] & (lvl > thr_v[c*LVL_W +: LVL_W])));
    end
    assign tier = |(avail & idle_v) ? (avail & idle_v) : avail;
    always_comb begin
      if (src_any_i[s]) cand[s] = tier;
      else begin
        cand[s] = '0;
        cand[s][src_cpu_i[s*CPU_W +: CPU_W]] = avail[src_cpu_i[s*CPU_W +: CPU_W]];
      end
    end
    assign has_cand[s] = pend[s] & (|cand[s]);
    assign grant[s]    = sel_vld && (sel_src == SRC_W'(s)) && gnt_vld;

    irq_steer_track #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (src_req_i[s]),
      .grant_i (grant[s]),
      .gcpu_i  (gnt_cpu),
      .ack_i   (irq_ack_i),
      .pend_o  (pend[s]),
      .wait_o  (waiting[s]),
      .cpu_o   (trk_cpu[s])
    );
  end

  always_comb begin
    sel_vld = 1'b0;
    sel_src = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (!sel_vld && has_cand[s]) begin
        sel_vld = 1'b1;
        sel_src = SRC_W'(s);
      end
    end
  end

  irq_steer_rr #(.N(N_CPU), .PW(CPU_W)) u_rr (
    .req_i (cand[sel_src]),
    .ptr_i (rr_q),
    .vld_o (gnt_vld),
    .idx_o (gnt_cpu)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (sel_vld && gnt_vld && src_any_i[sel_src])
      rr_q <= (gnt_cpu == CPU_W'(N_CPU-1)) ? '0 : gnt_cpu + 1'b1;
  end

  always_comb begin
    irq_o     = '0;
    irq_src_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (waiting[s]) begin
        irq_o[trk_cpu[s]] = 1'b1;
        irq_src_o[trk_cpu[s]*SRC_W +: SRC_W] = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int N_CPU = 8,
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int CPU_W = $clog2(N_CPU),
  parameter int SRC_W = $clog2(N_SRC)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CPU-1:0]           irq_o,
  input logic [N_CPU*SRC_W-1:0]     irq_src_o,
  input logic [N_CPU-1:0]           irq_ack_i,
  input logic [N_SRC-1:0]           src_any_i,
  input logic [N_SRC*CPU_W-1:0]     src_cpu_i,
  input logic [N_SRC*LVL_W-1:0]     src_lvl_i,
  input logic [N_CPU*(LVL_W+1)-1:0] steer_q
);
  localparam int REG_W = LVL_W + 1;
  localparam logic [REG_W-1:0] IDLE_C = {1'b1, {LVL_W{1'b0}}};
  localparam logic [REG_W-1:0] BUSY_C = {1'b1, {(LVL_W-1){1'b0}}, 1'b1};

  logic [N_CPU-1:0]       irq_d, rose, lvl_ok, pin_ok;
  logic [N_CPU*REG_W-1:0] steer_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_d   <= '0;
      steer_d <= '1;
    end else begin
      irq_d   <= irq_o;
      steer_d <= steer_q;
    end
  end

  assign rose = irq_o & ~irq_d;

  always_comb begin
    for (int c = 0; c < N_CPU; c++) begin
      logic [SRC_W-1:0] s;
      logic [REG_W-1:0] code;
      logic [LVL_W-1:0] lvl;
      s    = irq_src_o[c*SRC_W +: SRC_W];
      code = steer_d[c*REG_W +: REG_W];
      lvl  = src_lvl_i[s*LVL_W +: LVL_W];
      lvl_ok[c] = code[LVL_W] ? (code == IDLE_C || code == BUSY_C)
                              : (lvl > code[LVL_W-1:0]);
      pin_ok[c] = src_any_i[s] || (src_cpu_i[s*CPU_W +: CPU_W] == CPU_W'(c));
    end
  end

  AST_SINGLE_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rose)); // R11

  for (genvar c = 0; c < N_CPU; c++) begin : g_chk
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] && !irq_ack_i[c] |=> irq_o[c] && $stable(irq_src_o[c*SRC_W +: SRC_W])); // R9
    AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] && irq_ack_i[c] |=> !irq_o[c]); // R9
    AST_LEVEL_ADMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rose[c] |-> lvl_ok[c]); // R2
    AST_PINNED_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rose[c] |-> pin_ok[c]); // R4
  end
endmodule

bind irq_steer irq_steer_chk #(
  .N_CPU(N_CPU), .N_SRC(N_SRC), .LVL_W(LVL_W), .CPU_W(CPU_W), .SRC_W(SRC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .irq_src_o (irq_src_o),
  .irq_ack_i (irq_ack_i),
  .src_any_i (src_any_i),
  .src_cpu_i (src_cpu_i),
  .src_lvl_i (src_lvl_i),
  .steer_q   (steer_q)
);

// File: tb/irq_steer_test.sv
module irq_steer_test;
  localparam int N_CPU = 8, N_SRC = 8, LVL_W = 3;
  localparam int CPU_W = 3, SRC_W = 3, REG_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_CPU-1:0]       we = '0, ack = '0, irq;
  logic [N_CPU*REG_W-1:0] wdata = '0;
  logic [N_SRC-1:0]       req = '0, any = '0;
  logic [N_SRC*CPU_W-1:0] pin = '0;
  logic [N_SRC*LVL_W-1:0] lvl = '0;
  logic [N_CPU*SRC_W-1:0] isrc;

  always #10 clk = ~clk;

  irq_steer #(.N_CPU(N_CPU), .N_SRC(N_SRC), .LVL_W(LVL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .steer_we_i(we), .steer_wdata_i(wdata),
    .src_req_i(req), .src_any_i(any), .src_cpu_i(pin), .src_lvl_i(lvl),
    .irq_ack_i(ack), .irq_o(irq), .irq_src_o(isrc)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int exp_cpu[$], exp_src[$];
  string exp_tag[$];
  logic [N_CPU-1:0] irq_prev = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_irq(input int c, input int s, input string tag);
    exp_cpu.push_back(c); exp_src.push_back(s); exp_tag.push_back(tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int c, input logic [3:0] v);
    wdata[c*REG_W +: REG_W] = v; we[c] = 1'b1;
    @(negedge clk); we = '0;
  endtask

  task automatic fire(input logic [N_SRC-1:0] m);
    req = m; @(negedge clk); req = '0;
  endtask

  task automatic do_ack(input int c);
    ack[c] = 1'b1; @(negedge clk); ack = '0;
  endtask

  task automatic cfg(input int s, input bit a, input int c, input int l);
    any[s] = a; pin[s*CPU_W +: CPU_W] = CPU_W'(c); lvl[s*LVL_W +: LVL_W] = LVL_W'(l);
  endtask

  // monitor: every rising line is popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < N_CPU; c++) begin
        if (irq[c] && !irq_prev[c]) begin
          int s;
          s = int'(isrc[c*SRC_W +: SRC_W]);
          if (exp_cpu.size() == 0) check(1'b0, "unexpected delivery", c*16 + s, 0);
          else begin
            int ec, es;
            string et;
            ec = exp_cpu.pop_front(); es = exp_src.pop_front(); et = exp_tag.pop_front();
            check(ec == c && es == s, et, c*16 + s, ec*16 + es);
          end
        end
      end
      irq_prev = irq;
    end
  end

  initial begin
    cfg(0, 1, 0, 7); cfg(1, 1, 0, 4); cfg(2, 1, 0, 7); cfg(3, 1, 0, 7);
    cfg(4, 0, 2, 7); cfg(5, 1, 0, 7); cfg(6, 1, 0, 7); cfg(7, 1, 0, 7);
    cyc(3); rst_n = 1'b1; cyc(1);
    check(irq == '0, "R1 reset lines", irq, 0);

    // R1: reset code masks everything; R8: pending until a write opens a target
    fire(8'h01); cyc(4);
    check(irq == '0, "R1 no delivery before writes", irq, 0);
    expect_irq(3, 0, "R8 pending delivered after write");
    wr(3, 4'h9); cyc(2); do_ack(3);

    // R2: level must exceed threshold
    wr(3, 4'h4); fire(8'h02); cyc(4);
    check(irq == '0, "R2 level equal to threshold blocked", irq, 0);
    expect_irq(3, 1, "R2 level above threshold");
    wr(3, 4'h3); cyc(2); do_ack(3);

    // R3: 0xC masks all, 0x9 admits
    wr(3, 4'hC); wr(5, 4'h9);
    expect_irq(5, 2, "R3 busy admits, 0xC masks");
    fire(8'h04); cyc(2); do_ack(5);

    // R5: idle cpu1 beats busy cpu7 that comes first in scan (ptr=6)
    wr(1, 4'h8); wr(7, 4'h9);
    expect_irq(1, 0, "R5 idle preferred");
    fire(8'h01); cyc(2); do_ack(1);

    // R6/R7: no idle, rotating choice from ptr=2
    wr(1, 4'h0);
    expect_irq(5, 0, "R6 non-idle eligible chosen");
    fire(8'h01); cyc(2); do_ack(5);
    expect_irq(7, 0, "R7 pointer advanced");
    fire(8'h01); cyc(2); do_ack(7);
    expect_irq(1, 0, "R7 pointer wrapped");
    fire(8'h01); cyc(2); do_ack(1);

    // R4: pinned source waits on cpu2 only; R10 merge while waiting
    fire(8'h10); cyc(4);
    check(irq == '0, "R4 pinned ignores open cpus", irq, 0);
    expect_irq(2, 4, "R4 pinned delivered on its cpu");
    wr(2, 4'h6); cyc(2);
    fire(8'h10); cyc(3);
    check(irq == 8'h04, "R9 line held until ack", irq, 8'h04);
    check(isrc[2*SRC_W +: SRC_W] == 3'd4, "R9 source index stable", isrc[2*SRC_W +: SRC_W], 4);
    do_ack(2);
    check(irq == '0, "R9 line drops after ack", irq, 0);
    cyc(4);
    check(irq == '0, "R10 merged request not redispatched", irq, 0);

    // R9: a busy cpu is not eligible
    wr(2, 4'hF); wr(5, 4'hF); wr(7, 4'hF);
    expect_irq(1, 5, "R9 first to cpu1");
    fire(8'h20); cyc(2);
    fire(8'h40); cyc(4);
    check(irq == 8'h02, "R9 busy cpu not reused", irq, 8'h02);
    check(isrc[1*SRC_W +: SRC_W] == 3'd5, "R9 first source kept", isrc[1*SRC_W +: SRC_W], 5);
    expect_irq(1, 6, "R9 second after ack");
    do_ack(1); cyc(2); do_ack(1);

    // R11: simultaneous requests, lowest index first, one per cycle
    wr(7, 4'h9);
    expect_irq(7, 2, "R11 lower index first");
    expect_irq(1, 3, "R11 higher index next");
    fire(8'h0C); cyc(3);
    check(irq == 8'h82, "R11 both delivered", irq, 8'h82);
    ack = 8'h82; @(negedge clk); ack = '0;

    // R12: latency of two edges
    expect_irq(7, 0, "R12 latency");
    fire(8'h01);
    check(irq[7] == 1'b0, "R12 not yet after one edge", irq[7], 0);
    @(negedge clk);
    check(irq[7] == 1'b1, "R12 raised after second edge", irq[7], 1);
    do_ack(7); cyc(3);
    check(exp_cpu.size() == 0, "R8 all expected deliveries seen", exp_cpu.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule